// File: doc/BRIEF.md
# Dual Gated Timer/Counter

This block holds two independent 16-bit up-counting channels. Each channel is set up through a shared byte-wide mode register: two bits pick the width and reload behaviour, one bit picks the count source, and one bit ties counting to an external gate pin. A second byte-wide control register holds a run bit and an overflow flag for each channel. Software reaches both control registers and all four count bytes through a single-cycle register port. Reads return data one clock after the address is presented.

A channel advances only on cycles where the divided internal tick enable is high. In timer mode every such tick counts. In counter mode a tick counts only when the channel's external count pin was 1 at the previous tick and is 0 now. When a channel overflows it raises its sticky flag and gives a one-cycle pulse. The interrupt logic that consumes the flags clears one through an acknowledge input. Software can clear it with a write.

Top module: `dual_timer_unit`

## Requirements
- R1: After synchronous reset, every register (mode, control, the four count bytes) reads 0, and `ovf_flag` and `ovf_pulse` are 0.
- R2: The register addresses are: 0 mode, 1 control, 2 channel 0 low byte, 3 channel 0 high byte, 4 channel 1 low byte, 5 channel 1 high byte. The mode register holds channel 1 in bits 7:4 and channel 0 in bits 3:0, each nibble laid out as {gate, source, mode[1:0]}. The control register holds {flag1, run1, flag0, run0} in bits 7:4, and bits 3:0 read 0. `reg_rdata` shows the addressed register one cycle after the address.
- R3: In mode 01, a channel counts {high,low} as 16 bits. A step from FFFF wraps to 0000, sets the channel's flag and pulses `ovf_pulse` high for exactly one cycle.
- R4: A channel whose run bit is 0 holds its count whatever its tick, pin or gate inputs do.
- R5: With the gate bit at 1, a channel counts only while its `ext_gate` pin is 1. With the gate bit at 0, the pin has no effect.
- R6: With the source bit at 1, a channel advances once on each tick at which its `ext_cnt` pin is 0 and was 1 at the previous tick. A pin transition between ticks, or a steady pin, adds nothing.
- R7: In mode 00, bits 4:0 of the low byte form a prescaler into an 8-bit high byte. A step with prescaler 31 clears it and increments the high byte. Low-byte bits 7:5 are unchanged, and a step from high FF with prescaler 31 sets the flag.
- R8: In mode 10, only the low byte counts. A step from FF loads the high byte into the low byte and sets the flag.
- R9: Mode 11 on channel 0 splits it into two 8-bit counters. The low byte uses channel 0's run, gate and source bits and sets flag0. The high byte counts internal ticks under run1 and sets flag1, and channel 1 overflows then leave flag1 alone. Mode 11 on channel 1 freezes channel 1.
- R10: A flag clears on a control write that carries 0 in its position or on `ovf_ack`. An overflow in the same cycle as either leaves the flag set.
- R11: Writes and counting on one channel leave the other channel's count and flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Divided internal count enable, one cycle per tick |
| ext_cnt | input | 2 | External count pins, bit i for channel i |
| ext_gate | input | 2 | External gate pins, bit i for channel i |
| ovf_ack | input | 2 | Flag clear from the interrupt logic, per channel |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Registered read data |
| ovf_flag | output | 2 | Sticky overflow flags |
| ovf_pulse | output | 2 | One-cycle overflow pulses |

## Verification
Channel 0 is driven near each mode's wrap point (FFFF, prescaler 31 with high FF, low FF with reload value 80), so one or two ticks show whether the carry, the wrap and the reload each take the right path. Run, gate and source are varied with the pins held steady, toggled between ticks and toggled across ticks. This separates a correct sampled-edge counter from one that counts levels or raw edges. Split mode is run with both bytes at FF and then with channel 1 wrapping on its own, which shows which overflow owns flag1. A tick, a flag-clearing write and an acknowledge arriving in one cycle test that the set of a flag takes priority.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [1:0] {
    MODE_PRE13 = 2'b00,
    MODE_FULL  = 2'b01,
    MODE_RLD8  = 2'b10,
    MODE_SPLIT = 2'b11
  } tmr_mode_e;

  localparam int A_MODE   = 0;
  localparam int A_CTRL   = 1;
  localparam int A_CNT_LO = 2;  // channel i low byte at A_CNT_LO + 2*i
  localparam int NCH      = 2;
  localparam int NIB      = 4;  // mode nibble width per channel
endpackage

// File: rtl/tmr_edge_det.sv
module tmr_edge_det #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick_en,
  input  logic [N-1:0] pin,
  output logic [N-1:0] fall
);
  logic [N-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst)          prev_q <= '0;
    else if (tick_en) prev_q <= pin;
  end

  assign fall = {N{tick_en}} & prev_q & ~pin;

  // R6
  edge_only_on_tick_chk: assert property (@(posedge clk) disable iff (rst)
    !tick_en |-> (fall == '0));
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int PRE_W  = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  tmr_mode_e         mode,
  input  logic              step,
  input  logic              aux_step,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] cnt_lo,
  output logic [BYTE_W-1:0] cnt_hi,
  output logic              ovf_main,
  output logic              ovf_aux
);
  localparam int WIDE = 2 * BYTE_W;

  logic [BYTE_W-1:0] nxt_lo, nxt_hi;
  logic [WIDE-1:0]   sum_wide;

  assign sum_wide = {cnt_hi, cnt_lo} + 1'b1;

  always_comb begin
    nxt_lo   = cnt_lo;
    nxt_hi   = cnt_hi;
    ovf_main = 1'b0;
    ovf_aux  = 1'b0;
    unique case (mode)
      MODE_PRE13: if (step) begin
        if (&cnt_lo[PRE_W-1:0]) begin
          nxt_lo[PRE_W-1:0] = '0;
          nxt_hi            = cnt_hi + 1'b1;
          ovf_main          = &cnt_hi;
        end else begin
          nxt_lo[PRE_W-1:0] = cnt_lo[PRE_W-1:0] + 1'b1;
        end
      end
      MODE_FULL: if (step) begin
        {nxt_hi, nxt_lo} = sum_wide;
        ovf_main         = &{cnt_hi, cnt_lo};
      end
      MODE_RLD8: if (step) begin
        if (&cnt_lo) begin
          nxt_lo   = cnt_hi;
          ovf_main = 1'b1;
        end else begin
          nxt_lo = cnt_lo + 1'b1;
        end
      end
      MODE_SPLIT: begin
        if (step) begin
          nxt_lo   = cnt_lo + 1'b1;
          ovf_main = &cnt_lo;
        end
        if (aux_step) begin
          nxt_hi  = cnt_hi + 1'b1;
          ovf_aux = &cnt_hi;
        end
      end
      default: ;
    endcase
    if (wr_lo) nxt_lo = wdata;
    if (wr_hi) nxt_hi = wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_lo <= '0;
      cnt_hi <= '0;
    end else begin
      cnt_lo <= nxt_lo;
      cnt_hi <= nxt_hi;
    end
  end

  // R4
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !(step || aux_step || wr_lo || wr_hi) |=> $stable({cnt_hi, cnt_lo}));

  // R8
  reload_value_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_RLD8 && ovf_main && !wr_lo && !wr_hi) |=> (cnt_lo == cnt_hi));
endmodule

// File: rtl/dual_timer_unit.sv
module dual_timer_unit
  import tmr_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int PRE_W  = 5,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_en,
  input  logic [1:0]        ext_cnt,
  input  logic [1:0]        ext_gate,
  input  logic [1:0]        ovf_ack,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [BYTE_W-1:0] reg_wdata,
  output logic [BYTE_W-1:0] reg_rdata,
  output logic [1:0]        ovf_flag,
  output logic [1:0]        ovf_pulse
);
  localparam int BIT_F1 = BYTE_W - 1;
  localparam int BIT_G1 = BYTE_W - 2;
  localparam int BIT_F0 = BYTE_W - 3;
  localparam int BIT_G0 = BYTE_W - 4;

  logic [BYTE_W-1:0] mode_q;
  logic [NCH-1:0]    run_q;
  logic [NCH-1:0]    flag_q, flag_nxt, set_flag;
  logic [NCH-1:0]    fall, step, ovf_main, ovf_aux;
  logic [NCH-1:0]    wr_lo, wr_hi;
  logic [BYTE_W-1:0] cnt_lo [NCH];
  logic [BYTE_W-1:0] cnt_hi [NCH];
  logic [BYTE_W-1:0] ctrl_view;
  logic              wr_mode, wr_ctrl, split0;

  assign wr_mode = reg_we && (reg_addr == ADDR_W'(A_MODE));
  assign wr_ctrl = reg_we && (reg_addr == ADDR_W'(A_CTRL));
  assign split0  = (tmr_mode_e'(mode_q[1:0]) == MODE_SPLIT);

  tmr_edge_det #(.N(NCH)) u_edge (
    .clk(clk), .rst(rst), .tick_en(tick_en), .pin(ext_cnt), .fall(fall)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    tmr_mode_e ch_mode;
    logic      allow, src, halted, aux;

    assign ch_mode  = tmr_mode_e'(mode_q[NIB*i +: 2]);
    assign allow    = run_q[i] & (~mode_q[NIB*i+3] | ext_gate[i]);
    assign src      = mode_q[NIB*i+2] ? fall[i] : tick_en;
    // channel 1 freezes in split mode; channel 0 splits instead
    assign halted   = (i != 0) && (ch_mode == MODE_SPLIT);
    assign aux      = (i == 0) ? (tick_en & run_q[1]) : 1'b0;
    assign step[i]  = allow & src & ~halted;
    assign wr_lo[i] = reg_we && (reg_addr == ADDR_W'(A_CNT_LO + 2*i));
    assign wr_hi[i] = reg_we && (reg_addr == ADDR_W'(A_CNT_LO + 2*i + 1));

    tmr_channel #(.BYTE_W(BYTE_W), .PRE_W(PRE_W)) u_chan (
      .clk(clk), .rst(rst), .mode(ch_mode), .step(step[i]), .aux_step(aux),
      .wr_lo(wr_lo[i]), .wr_hi(wr_hi[i]), .wdata(reg_wdata),
      .cnt_lo(cnt_lo[i]), .cnt_hi(cnt_hi[i]),
      .ovf_main(ovf_main[i]), .ovf_aux(ovf_aux[i])
    );
  end

  assign set_flag[0] = ovf_main[0];
  assign set_flag[1] = split0 ? ovf_aux[0] : (ovf_main[1] | ovf_aux[1]);

  always_comb begin
    for (int i = 0; i < NCH; i++) begin
      flag_nxt[i] = flag_q[i];
      if (ovf_ack[i]) flag_nxt[i] = 1'b0;
      if (wr_ctrl)    flag_nxt[i] = (i == 0) ? reg_wdata[BIT_F0] : reg_wdata[BIT_F1];
      if (set_flag[i]) flag_nxt[i] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q    <= '0;
      run_q     <= '0;
      flag_q    <= '0;
      ovf_pulse <= '0;
    end else begin
      if (wr_mode) mode_q <= reg_wdata;
      if (wr_ctrl) run_q  <= {reg_wdata[BIT_G1], reg_wdata[BIT_G0]};
      flag_q    <= flag_nxt;
      ovf_pulse <= set_flag;
    end
  end

  assign ovf_flag  = flag_q;
  assign ctrl_view = {flag_q[1], run_q[1], flag_q[0], run_q[0], {(BYTE_W-4){1'b0}}};

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else begin
      unique case (int'(reg_addr))
        A_MODE:       reg_rdata <= mode_q;
        A_CTRL:       reg_rdata <= ctrl_view;
        A_CNT_LO:     reg_rdata <= cnt_lo[0];
        A_CNT_LO + 1: reg_rdata <= cnt_hi[0];
        A_CNT_LO + 2: reg_rdata <= cnt_lo[1];
        A_CNT_LO + 3: reg_rdata <= cnt_hi[1];
        default:      reg_rdata <= '0;
      endcase
    end
  end

  // R10
  pulse_implies_flag0_chk: assert property (@(posedge clk) disable iff (rst)
    ovf_pulse[0] |-> ovf_flag[0]);
  // R10
  pulse_implies_flag1_chk: assert property (@(posedge clk) disable iff (rst)
    ovf_pulse[1] |-> ovf_flag[1]);
  // R10
  flag_clear_cause_chk: assert property (@(posedge clk) disable iff (rst)
    ($fell(ovf_flag[0]) || $fell(ovf_flag[1])) |-> $past(wr_ctrl || (ovf_ack != '0)));
  // R9
  ch1_halt_chk: assert property (@(posedge clk) disable iff (rst)
    (tmr_mode_e'(mode_q[NIB+1:NIB]) == MODE_SPLIT && !wr_lo[1] && !wr_hi[1])
      |=> $stable({cnt_hi[1], cnt_lo[1]}));
endmodule

// File: tb/dual_timer_unit_bench.sv
module dual_timer_unit_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick_en = 1'b0;
  logic [1:0] ext_cnt = '0, ext_gate = '0, ovf_ack = '0;
  logic       reg_we = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic [1:0] ovf_flag, ovf_pulse;

  int checks = 0, errors = 0;
  bit done = 1'b0;
  logic rd_strobe = 1'b0, chk_vld = 1'b0;
  logic [7:0] exp_q [$];
  string      tag_q [$];

  always #5 clk = ~clk;

  dual_timer_unit u_dual_timer_unit (
    .clk(clk), .rst(rst), .tick_en(tick_en), .ext_cnt(ext_cnt),
    .ext_gate(ext_gate), .ovf_ack(ovf_ack), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .ovf_flag(ovf_flag), .ovf_pulse(ovf_pulse)
  );

  always @(posedge clk) chk_vld <= rd_strobe;

  // scoreboard monitor: compares returned read data against queued expectations
  always @(negedge clk) begin
    if (chk_vld && exp_q.size() > 0) begin
      logic [7:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (reg_rdata !== e) begin
        errors++;
        $display("FAIL %s rdata got %02h expected %02h", t, reg_rdata, e);
      end
    end
  end

  task automatic chk2(input logic [1:0] got, input logic [1:0] exp, input string t);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %b expected %b", t, got, exp);
    end
  endtask

  task automatic wr(input int a, input logic [7:0] d);
    reg_we = 1'b1; reg_addr = 3'(a); reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input int a, input logic [7:0] e, input string t);
    reg_addr = 3'(a);
    exp_q.push_back(e);
    tag_q.push_back(t);
    rd_strobe = 1'b1;
    @(negedge clk);
    rd_strobe = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int k = 0; k < n; k++) begin
      tick_en = 1'b1; @(negedge clk);
      tick_en = 1'b0; @(negedge clk);
    end
  endtask

  task automatic pulse_tick(input logic [1:0] exp, input string t);
    tick_en = 1'b1; @(negedge clk);
    chk2(ovf_pulse, exp, {t, " pulse"});
    chk2(ovf_flag & exp, exp, {t, " flag"});
    tick_en = 1'b0; @(negedge clk);
    chk2(ovf_pulse, 2'b00, {t, " pulse width"});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk2(ovf_flag, 2'b00, "R1 flags");
    chk2(ovf_pulse, 2'b00, "R1 pulses");
    for (int a = 0; a < 6; a++) rd(a, 8'h00, "R1 reg");

    // R3 full 16-bit wrap on channel 0
    wr(0, 8'h01); wr(2, 8'hFE); wr(3, 8'hFF); wr(1, 8'h10);
    ticks(1);
    rd(2, 8'hFF, "R3 lo"); rd(3, 8'hFF, "R3 hi");
    chk2(ovf_flag, 2'b00, "R3 no early flag");
    pulse_tick(2'b01, "R3 wrap");
    rd(2, 8'h00, "R3 lo wrap"); rd(3, 8'h00, "R3 hi wrap");
    rd(1, 8'h30, "R2 ctrl layout");

    // R10 software clear
    wr(1, 8'h10);
    rd(1, 8'h10, "R10 write clear");

    // R4 run bit off freezes
    wr(1, 8'h00); ticks(3);
    rd(2, 8'h00, "R4 frozen");

    // R5 gate
    wr(0, 8'h09); wr(1, 8'h10);
    ticks(3);
    rd(2, 8'h00, "R5 gate low");
    ext_gate = 2'b01; ticks(2);
    rd(2, 8'h02, "R5 gate high");

    // R6 external falling edges sampled at ticks
    wr(0, 8'h05); wr(2, 8'h00);
    ext_cnt = 2'b01; ticks(1);
    ext_cnt = 2'b00; ticks(1);
    ticks(2);
    ext_cnt = 2'b01; ticks(1);
    ext_cnt = 2'b00; ticks(1);
    rd(2, 8'h02, "R6 two edges");
    ext_cnt = 2'b01; repeat (2) @(negedge clk);
    ext_cnt = 2'b00; repeat (2) @(negedge clk);
    ticks(1);
    rd(2, 8'h02, "R6 edge between ticks");

    // R7 13-bit mode
    wr(0, 8'h00); wr(2, 8'h1F); wr(3, 8'h00);
    ticks(1);
    rd(2, 8'h00, "R7 prescaler wrap"); rd(3, 8'h01, "R7 carry");
    wr(2, 8'hFF); wr(3, 8'hFF);
    pulse_tick(2'b01, "R7 overflow");
    rd(2, 8'hE0, "R7 upper bits kept"); rd(3, 8'h00, "R7 hi wrap");

    // R8 reload mode
    wr(0, 8'h02); wr(1, 8'h10); wr(3, 8'h80); wr(2, 8'hFE);
    ticks(1);
    rd(2, 8'hFF, "R8 count");
    chk2(ovf_flag, 2'b00, "R8 no flag yet");
    ticks(1);
    rd(2, 8'h80, "R8 reload");
    chk2(ovf_flag, 2'b01, "R8 flag");
    ticks(1);
    rd(2, 8'h81, "R8 after reload");

    // R10 acknowledge clear, then set beats clear
    ovf_ack = 2'b01; @(negedge clk); ovf_ack = 2'b00;
    chk2(ovf_flag, 2'b00, "R10 ack clear");
    wr(2, 8'hFF);
    tick_en = 1'b1; reg_we = 1'b1; reg_addr = 3'd1; reg_wdata = 8'h10; ovf_ack = 2'b01;
    @(negedge clk);
    tick_en = 1'b0; reg_we = 1'b0; ovf_ack = 2'b00;
    chk2(ovf_flag, 2'b01, "R10 set wins");
    rd(2, 8'h80, "R10 reload same cycle");

    // R9 split mode
    wr(0, 8'h13); wr(1, 8'h50);
    wr(2, 8'hFF); wr(3, 8'hFF); wr(4, 8'h10); wr(5, 8'h00);
    pulse_tick(2'b11, "R9 split");
    rd(2, 8'h00, "R9 lo"); rd(3, 8'h00, "R9 hi");
    rd(4, 8'h11, "R9 ch1 runs"); rd(1, 8'hF0, "R9 ctrl");
    rd(0, 8'h13, "R2 mode readback");
    wr(0, 8'h33); ticks(2);
    rd(4, 8'h11, "R9 ch1 halted"); rd(2, 8'h02, "R9 lo"); rd(3, 8'h02, "R9 hi");
    wr(1, 8'h50); wr(0, 8'h13); wr(4, 8'hFF); wr(5, 8'hFF);
    ticks(1);
    chk2(ovf_flag, 2'b00, "R9 ch1 wrap no flag");
    rd(4, 8'h00, "R9 ch1 wrapped"); rd(3, 8'h03, "R9 hi run1");

    // R11 channel 1 alone
    wr(0, 8'h10); wr(1, 8'h40); wr(4, 8'hFF); wr(5, 8'hFF);
    pulse_tick(2'b10, "R11 ch1 wrap");
    rd(4, 8'h00, "R11 lo1"); rd(5, 8'h00, "R11 hi1");
    rd(2, 8'h03, "R11 ch0 untouched"); rd(1, 8'hC0, "R11 ctrl");

    // R5 R6 on channel 1: gated external counting
    wr(0, 8'hD0); wr(1, 8'h40);
    ext_gate = 2'b00;
    ext_cnt = 2'b10; ticks(1); ext_cnt = 2'b00; ticks(1);
    rd(4, 8'h00, "R5 ch1 gate low");
    ext_gate = 2'b10;
    ext_cnt = 2'b10; ticks(1); ext_cnt = 2'b00; ticks(1);
    rd(4, 8'h01, "R6 ch1 edge count");

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule